// File: doc/BRIEF.md
# T1 Transmit Per-Channel Conditioner

This block sits on the byte-wide transmit payload path of a T1 framer. Each cycle in which `in_valid` is high it receives one DS0 channel byte, the index of that channel (1 to 24), and the current frame number within the superframe. It also receives the framing format (D4 or ESF), the four signaling bits for the channel, the yellow-alarm request and a set of per-channel configuration masks. It returns the conditioned byte one cycle later with a matching strobe.

Four operations are applied in a fixed order. First, idle-code substitution replaces the byte for channels marked idle. Second, robbed-bit signaling overwrites the least significant bit in signaling frames. Third, zero-code stuffing sets bit 7 when the byte would otherwise be all zeros. Fourth, in D4 only, the yellow alarm forces bit 2 low on every channel. A per-channel clear mask removes a channel from signaling and from stuffing. A global stuff-all control, which needs both of its enable bits set, brings stuffing back onto every channel.

Bit numbering follows T1 practice. Bit 1 is the byte MSB (`[7]`) and is sent first. Bit 2 is `[6]`, bit 7 is `[1]`, and bit 8 is the LSB (`[0]`).

Top module: `t1_tx_chan_cond`

## Requirements
- R1: While `rst_n` is low at a clock edge, the output registers load `out_byte` = 8'hFF, `out_valid` = 0 and `out_chan` = 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. `out_byte` and `out_chan` change only one clock after a cycle with `in_valid` high, and otherwise hold their value.
- R3: For channel k (1..24), mask bit k-1 of `idle_mask` set replaces the channel byte with `idle_code` before any other step.
- R4: In D4 (`fmt_esf` = 0), for a channel whose `clear_mask` bit is 0, bit 8 (`[0]`) is overwritten with signaling A (`sig_abcd[0]`) in frame 6 and B (`sig_abcd[1]`) in frame 12. All other frames are left as they are.
- R5: In ESF (`fmt_esf` = 1), for a channel whose `clear_mask` bit is 0, bit 8 is overwritten with A, B, C and D (`sig_abcd[0..3]`) in frames 6, 12, 18 and 24 respectively.
- R6: A channel whose `clear_mask` bit is 1 gets no signaling and no stuffing, provided the stuff-all control is off.
- R7: An eligible channel whose byte is 8'h00 after idle and signaling steps is sent as 8'h02 (bit 7 set). A channel is eligible when its clear bit is 0 or stuff-all is on.
- R8: Stuff-all is `stuff_cfg_a AND stuff_cfg_b`. When it is on, stuffing applies to all 24 channels. The clear mask then only gates signaling. Either enable alone has no effect.
- R9: In D4 with `yellow_tx` = 1, bit 2 (`[6]`) of every channel is forced to 0 as the final step, including clear and idle channels. In ESF, `yellow_tx` has no effect on the payload.
- R10: A channel index outside 1..24 passes the byte through unchanged except for the R9 forcing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Channel byte strobe |
| in_chan | input | 5 | Channel index, 1..24 |
| in_byte | input | 8 | Payload byte, [7] = bit 1 |
| frame_num | input | 5 | Frame number in superframe, 1..24 |
| fmt_esf | input | 1 | 0 = D4, 1 = ESF |
| sig_abcd | input | 4 | Signaling bits for this channel, [0]=A .. [3]=D |
| yellow_tx | input | 1 | Yellow alarm being transmitted |
| clear_mask | input | 24 | Per-channel clear control, bit k-1 = channel k |
| idle_mask | input | 24 | Per-channel idle control, bit k-1 = channel k |
| idle_code | input | 8 | Idle code byte |
| stuff_cfg_a | input | 1 | First stuff-all enable |
| stuff_cfg_b | input | 1 | Second stuff-all enable |
| out_valid | output | 1 | Strobe for out_byte |
| out_chan | output | 5 | Channel index of out_byte |
| out_byte | output | 8 | Conditioned byte |

## Verification
Every conditioning result comes through exactly one register. The byte driven on a falling edge therefore appears on `out_byte` after the next rising edge. The bench drives on falling edges and compares one falling edge later, and computes the expected byte from the requirements at that point. The hold behaviour of R2 is checked by dropping the strobe and changing the inputs, then confirming one cycle later that the outputs have not moved. The reset value is sampled on the falling edge after a rising edge with `rst_n` low.

// File: rtl/t1c_pkg.sv
// t1c_pkg: shared constants and types for the T1 transmit conditioner.
// Assumes a 24-channel T1 frame and byte-wide channel slots.
package t1c_pkg;

    localparam int T1_NUM_CH    = 24;
    localparam int T1_BYTE_W    = 8;
    localparam int T1_SIG_W     = 4;
    localparam int T1_SIG_STEP  = 6;

    // Framing format selector.
    typedef enum logic {
        FMT_D4  = 1'b0,
        FMT_ESF = 1'b1
    } t1_fmt_e;

    // Per-channel controls after decode.
    typedef struct packed {
        logic in_range;
        logic clear;
        logic idle;
    } t1_chan_ctl_t;

    // T1 bit positions mapped onto a byte vector ([7] is sent first).
    localparam int T1_POS_BIT2 = 6;
    localparam int T1_POS_BIT7 = 1;
    localparam int T1_POS_BIT8 = 0;

endpackage

// File: rtl/t1c_chan_decode.sv
// t1c_chan_decode: turns a 1-based channel index into that channel's clear
// and idle controls from the per-channel masks.
// Assumes mask bit k-1 belongs to channel k; indices outside 1..NUM_CH
// report in_range = 0 with clear and idle forced low.
module t1c_chan_decode
    import t1c_pkg::*;
#(
    parameter int NUM_CH = T1_NUM_CH,
    parameter int CH_W   = $clog2(NUM_CH + 1)
) (
    input  logic [CH_W-1:0]   chan,
    input  logic [NUM_CH-1:0] clear_mask,
    input  logic [NUM_CH-1:0] idle_mask,
    output t1_chan_ctl_t      ctl
);

    logic [NUM_CH-1:0] hit;

    // One comparator per channel builds a one-hot select.
    genvar k;
    generate
        for (k = 0; k < NUM_CH; k++) begin : g_hit
            assign hit[k] = (chan == CH_W'(k + 1));
        end
    endgenerate

    // Reduce the one-hot select against each mask.
    always_comb begin
        ctl.in_range = |hit;
        ctl.clear    = |(hit & clear_mask);
        ctl.idle     = |(hit & idle_mask);
    end

endmodule

// File: rtl/t1c_sig_select.sv
// t1c_sig_select: decides whether the current frame carries robbed-bit
// signaling and which signaling bit belongs in it.
// Assumes signaling frames fall every SIG_STEP frames; D4 uses the first
// two slots (A, B) and ESF all NUM_SIG slots (A..D).
module t1c_sig_select
    import t1c_pkg::*;
#(
    parameter int FRAME_W  = 5,
    parameter int NUM_SIG  = T1_SIG_W,
    parameter int SIG_STEP = T1_SIG_STEP,
    parameter int D4_SIGS  = 2
) (
    input  t1_fmt_e            fmt,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic [NUM_SIG-1:0] sig_bits,
    output logic               sig_hit,
    output logic               sig_val
);

    logic [NUM_SIG-1:0] slot_hit;
    logic [NUM_SIG-1:0] slot_ok;

    // One frame match per signaling slot, masked by format.
    genvar s;
    generate
        for (s = 0; s < NUM_SIG; s++) begin : g_slot
            assign slot_hit[s] = (frame_num == FRAME_W'(SIG_STEP * (s + 1)));
            if (s < D4_SIGS) begin : g_both
                assign slot_ok[s] = 1'b1;
            end else begin : g_esf
                assign slot_ok[s] = (fmt == FMT_ESF);
            end
        end
    endgenerate

    // Pick the signaling bit of the active slot, if any.
    always_comb begin
        sig_hit = |(slot_hit & slot_ok);
        sig_val = |(slot_hit & slot_ok & sig_bits);
    end

endmodule

// File: rtl/t1c_byte_cond.sv
// t1c_byte_cond: combinational conditioning of one channel byte in the fixed
// order idle -> signaling -> zero stuff -> yellow bit-2 forcing.
// Assumes ctl has been decoded for this byte; out-of-range channels skip
// every step except the alarm forcing.
module t1c_byte_cond
    import t1c_pkg::*;
#(
    parameter int BYTE_W = T1_BYTE_W
) (
    input  logic [BYTE_W-1:0] raw_byte,
    input  t1_chan_ctl_t      ctl,
    input  logic [BYTE_W-1:0] idle_code,
    input  logic              sig_hit,
    input  logic              sig_val,
    input  logic              stuff_all,
    input  logic              yellow_d4,
    output logic [BYTE_W-1:0] cond_byte
);

    logic [BYTE_W-1:0] after_idle;
    logic [BYTE_W-1:0] after_sig;
    logic [BYTE_W-1:0] after_stuff;
    logic              stuff_ok;

    // Step 1: idle-code substitution.
    always_comb begin
        after_idle = (ctl.in_range && ctl.idle) ? idle_code : raw_byte;
    end

    // Step 2: robbed-bit signaling into bit 8 of non-clear channels.
    always_comb begin
        after_sig = after_idle;
        if (ctl.in_range && !ctl.clear && sig_hit) begin
            after_sig[T1_POS_BIT8] = sig_val;
        end
    end

    // Step 3: bit 7 stuffing of an all-zero byte on eligible channels.
    always_comb begin
        stuff_ok    = ctl.in_range && (!ctl.clear || stuff_all);
        after_stuff = after_sig;
        if (stuff_ok && (after_sig == '0)) begin
            after_stuff[T1_POS_BIT7] = 1'b1;
        end
    end

    // Step 4: yellow alarm in D4 clears bit 2 on every channel.
    always_comb begin
        cond_byte = after_stuff;
        if (yellow_d4) begin
            cond_byte[T1_POS_BIT2] = 1'b0;
        end
    end

endmodule

// File: rtl/t1_tx_chan_cond.sv
// t1_tx_chan_cond: top of the T1 transmit per-channel conditioner.
// Decodes channel controls, selects signaling, conditions the byte and
// registers the result with one clock of latency.
// Assumes one channel byte per in_valid cycle; reset is synchronous,
// active low, and loads the all-ones idle default.
module t1_tx_chan_cond
    import t1c_pkg::*;
#(
    parameter int NUM_CH  = T1_NUM_CH,
    parameter int BYTE_W  = T1_BYTE_W,
    parameter int NUM_SIG = T1_SIG_W,
    parameter int FRAME_W = 5,
    parameter int CH_W    = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_chan,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [FRAME_W-1:0] frame_num,
    input  logic              fmt_esf,
    input  logic [NUM_SIG-1:0] sig_abcd,
    input  logic              yellow_tx,
    input  logic [NUM_CH-1:0] clear_mask,
    input  logic [NUM_CH-1:0] idle_mask,
    input  logic [BYTE_W-1:0] idle_code,
    input  logic              stuff_cfg_a,
    input  logic              stuff_cfg_b,
    output logic              out_valid,
    output logic [CH_W-1:0]   out_chan,
    output logic [BYTE_W-1:0] out_byte
);

    localparam logic [BYTE_W-1:0] RESET_BYTE = '1;

    t1_fmt_e           fmt;
    t1_chan_ctl_t      ctl;
    logic              sig_hit;
    logic              sig_val;
    logic              stuff_all;
    logic              yellow_d4;
    logic [BYTE_W-1:0] cond_byte;

    // Global controls derived from configuration inputs.
    always_comb begin
        fmt       = t1_fmt_e'(fmt_esf);
        stuff_all = stuff_cfg_a & stuff_cfg_b;
        yellow_d4 = yellow_tx && (fmt == FMT_D4);
    end

    t1c_chan_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_decode (
        .chan       (in_chan),
        .clear_mask (clear_mask),
        .idle_mask  (idle_mask),
        .ctl        (ctl)
    );

    t1c_sig_select #(
        .FRAME_W  (FRAME_W),
        .NUM_SIG  (NUM_SIG),
        .SIG_STEP (T1_SIG_STEP),
        .D4_SIGS  (2)
    ) u_sig (
        .fmt       (fmt),
        .frame_num (frame_num),
        .sig_bits  (sig_abcd),
        .sig_hit   (sig_hit),
        .sig_val   (sig_val)
    );

    t1c_byte_cond #(
        .BYTE_W (BYTE_W)
    ) u_cond (
        .raw_byte  (in_byte),
        .ctl       (ctl),
        .idle_code (idle_code),
        .sig_hit   (sig_hit),
        .sig_val   (sig_val),
        .stuff_all (stuff_all),
        .yellow_d4 (yellow_d4),
        .cond_byte (cond_byte)
    );

    // Output strobe tracks the input strobe one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Output byte and channel load only on strobed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= RESET_BYTE;
            out_chan <= '0;
        end else if (in_valid) begin
            out_byte <= cond_byte;
            out_chan <= in_chan;
        end
    end

endmodule

// File: rtl/t1c_checker.sv
// t1c_checker: temporal properties of t1_tx_chan_cond, attached by bind.
// Assumes the default 24-channel, 8-bit configuration of the top.
module t1c_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [4:0]  in_chan,
    input logic [7:0]  in_byte,
    input logic        fmt_esf,
    input logic        yellow_tx,
    input logic [23:0] clear_mask,
    input logic [23:0] idle_mask,
    input logic [7:0]  idle_code,
    input logic        stuff_cfg_a,
    input logic        stuff_cfg_b,
    input logic        out_valid,
    input logic [7:0]  out_byte
);

    logic in_rng;
    logic ch_clear;
    logic ch_idle;
    logic all_on;
    logic yel_d4;

    // Independent per-channel lookup by loop over channels.
    always_comb begin
        in_rng   = (in_chan >= 5'd1) && (in_chan <= 5'd24);
        ch_clear = 1'b0;
        ch_idle  = 1'b0;
        for (int i = 0; i < 24; i++) begin
            if (in_chan == 5'(i + 1)) begin
                ch_clear = clear_mask[i];
                ch_idle  = idle_mask[i];
            end
        end
        all_on = stuff_cfg_a && stuff_cfg_b;
        yel_d4 = yellow_tx && !fmt_esf;
    end

    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_byte));

    assert_idle_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rng && ch_idle && ch_clear && !all_on && !yel_d4)
        |=> out_byte == $past(idle_code));

    assert_clear_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rng && ch_clear && !ch_idle && !all_on && !yel_d4)
        |=> out_byte == $past(in_byte));

    assert_no_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rng && (!ch_clear || all_on) && !yel_d4)
        |=> out_byte != 8'h00);

    assert_yellow_bit2_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && yel_d4) |=> !out_byte[6]);

    assert_out_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_rng && !yel_d4) |=> out_byte == $past(in_byte));

endmodule

bind t1_tx_chan_cond t1c_checker u_t1c_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_chan     (in_chan),
    .in_byte     (in_byte),
    .fmt_esf     (fmt_esf),
    .yellow_tx   (yellow_tx),
    .clear_mask  (clear_mask),
    .idle_mask   (idle_mask),
    .idle_code   (idle_code),
    .stuff_cfg_a (stuff_cfg_a),
    .stuff_cfg_b (stuff_cfg_b),
    .out_valid   (out_valid),
    .out_byte    (out_byte)
);

// File: tb/tb_t1_tx_chan_cond.sv
// tb_t1_tx_chan_cond: sweep over channels, frames, formats, alarm, stuff
// controls and byte patterns with an arithmetic reference model.
`timescale 1ns/1ps
module tb_t1_tx_chan_cond;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_chan = '0;
    logic [7:0]  in_byte = '0;
    logic [4:0]  frame_num = '0;
    logic        fmt_esf = 1'b0;
    logic [3:0]  sig_abcd = '0;
    logic        yellow_tx = 1'b0;
    logic [23:0] clear_mask = '0;
    logic [23:0] idle_mask = '0;
    logic [7:0]  idle_code = '0;
    logic        stuff_cfg_a = 1'b0;
    logic        stuff_cfg_b = 1'b0;
    logic        out_valid;
    logic [4:0]  out_chan;
    logic [7:0]  out_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    t1_tx_chan_cond dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_byte(in_byte), .frame_num(frame_num), .fmt_esf(fmt_esf),
        .sig_abcd(sig_abcd), .yellow_tx(yellow_tx), .clear_mask(clear_mask),
        .idle_mask(idle_mask), .idle_code(idle_code),
        .stuff_cfg_a(stuff_cfg_a), .stuff_cfg_b(stuff_cfg_b),
        .out_valid(out_valid), .out_chan(out_chan), .out_byte(out_byte)
    );

    // Reference byte computed from the requirement text.
    function automatic logic [7:0] ref_byte();
        logic [7:0] b;
        logic in_rng, clr, idl;
        b      = in_byte;
        in_rng = (in_chan >= 1) && (in_chan <= 24);
        if (in_rng) begin
            clr = clear_mask[in_chan - 1];
            idl = idle_mask[in_chan - 1];
            if (idl) b = idle_code;
            if (!clr) begin
                if (frame_num == 6)                 b[0] = sig_abcd[0];
                else if (frame_num == 12)           b[0] = sig_abcd[1];
                else if (fmt_esf && frame_num == 18) b[0] = sig_abcd[2];
                else if (fmt_esf && frame_num == 24) b[0] = sig_abcd[3];
            end
            if ((!clr || (stuff_cfg_a && stuff_cfg_b)) && b == 8'h00) b = 8'h02;
        end
        if (!fmt_esf && yellow_tx) b[6] = 1'b0;
        return b;
    endfunction

    // Requirement that governs the current stimulus, for messages.
    function automatic string req_tag();
        if (!(in_chan >= 1 && in_chan <= 24)) return "R10";
        if (!fmt_esf && yellow_tx) return "R9";
        if (idle_mask[in_chan - 1]) return "R3";
        if (clear_mask[in_chan - 1])
            return (stuff_cfg_a && stuff_cfg_b) ? "R8" : "R6";
        if (frame_num == 6 || frame_num == 12 || frame_num == 18 || frame_num == 24)
            return fmt_esf ? "R5" : "R4";
        return "R7";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one strobed byte at a falling edge, compare one falling edge later.
    task automatic step();
        logic [7:0] e;
        string t;
        in_valid = 1'b1;
        e = ref_byte();
        t = req_tag();
        @(negedge clk);
        check(t, {24'd0, out_byte}, {24'd0, e});
        check("R2", {31'd0, out_valid}, 32'd1);
        check("R2", {27'd0, out_chan}, {27'd0, in_chan});
    endtask

    initial begin
        logic [7:0] held;
        logic [7:0] pats [5];
        logic [4:0] frames [5];
        pats   = '{8'h00, 8'h01, 8'h40, 8'hFF, 8'h5A};
        frames = '{5'd1, 5'd6, 5'd12, 5'd18, 5'd24};

        // R1: reset state after an edge with rst_n low.
        @(negedge clk);
        @(negedge clk);
        check("R1", {24'd0, out_byte}, 32'hFF);
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", {27'd0, out_chan}, 32'd0);
        rst_n = 1'b1;

        // R3..R10: sweep of the function.
        for (int set = 0; set < 2; set++) begin
            clear_mask = set ? 24'h3C3C3C : 24'hA5A5A5;
            idle_mask  = set ? 24'hA5A5A5 : 24'h3C3C3C;
            idle_code  = set ? 8'hC3 : 8'h00;
            for (int st = 0; st < 4; st++) begin
                stuff_cfg_a = st[0];
                stuff_cfg_b = st[1];
                for (int md = 0; md < 4; md++) begin
                    fmt_esf   = md[0];
                    yellow_tx = md[1];
                    for (int f = 0; f < 5; f++) begin
                        frame_num = frames[f];
                        for (int p = 0; p < 5; p++) begin
                            in_byte = pats[p];
                            for (int c = 0; c < 27; c++) begin
                                in_chan  = (c == 26) ? 5'd31 : 5'(c);
                                sig_abcd = in_chan[3:0] ^ 4'b0101;
                                step();
                            end
                        end
                    end
                end
            end
        end

        // R2: strobe low holds outputs while inputs change.
        for (int h = 0; h < 4; h++) begin
            held     = out_byte;
            in_valid = 1'b0;
            in_byte  = 8'h81 + 8'(h);
            in_chan  = 5'(h + 3);
            @(negedge clk);
            check("R2", {24'd0, out_byte}, {24'd0, held});
            check("R2", {31'd0, out_valid}, 32'd0);
        end

        // R1: reset reasserted mid-run restores the idle default.
        in_valid = 1'b1;
        rst_n    = 1'b0;
        @(negedge clk);
        check("R1", {24'd0, out_byte}, 32'hFF);
        check("R1", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule